// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block turns data-side virtual addresses into physical addresses using a small set-associative lookaside buffer. Each way of each set holds two records. The match record carries a page tag, a valid flag and an age counter. The translate record carries a physical page number, a cache-inhibit flag and four access enables: read and write for user mode, and read and write for supervisor mode. Software fills both records through a register write port and can read any record back through a read port. Nothing is refilled by hardware. A miss is reported to the surrounding logic, which runs the handler.

A main lookup takes an address, a write flag and a privilege flag, and reports one result: hit, miss or page fault. It also returns the physical address and a cache-inhibit flag. A hit ages the counters of its set. A second, probe lookup runs the same translation and permission check. It never reports a fault and never touches the counters. Its cache-inhibit output changes only when the caller asks for it. When translation is off, or the build has no translator fitted, addresses pass through unchanged. In that case the top half of the address space is treated as cache-inhibited.

Top module: `dtlb_xlate`

## Requirements
- R1: When xlat_en is 0, or the build parameter MMU_FITTED is 0, a main lookup returns rsp_paddr equal to the request address, rsp_ci equal to address bit 31 (set for 0x80000000 and above), and rsp_kind HIT (2'd0). The age counters do not change.
- R2: The set index is address bits [14:13] (8 KiB pages, 4 sets) and the tag is bits [31:15]. A way matches only if its valid flag is set and its stored tag equals the tag. If several ways match, the highest-numbered way is used.
- R3: On a match with req_super=1, a write needs the supervisor write enable and a read needs the supervisor read enable. If the enable is clear, rsp_kind is FAULT (2'd2), and rsp_paddr and rsp_ci are 0.
- R4: On a match with req_super=0, a write needs the user write enable and a read needs the user read enable. A denied access gives FAULT with rsp_paddr and rsp_ci equal to 0.
- R5: A permitted match gives rsp_kind HIT, rsp_paddr = {physical page number, address bits [12:0]}, and rsp_ci = the cache-inhibit flag of the matching translate record.
- R6: With no match, rsp_kind is MISS (2'd1), and rsp_paddr and rsp_ci are 0. No record is written.
- R7: On any match, including one that faults, the matching way's age counter is set to NWAYS-1 (1 by default). Every other way in the set whose counter is nonzero is decremented by one. Misses and pass-through lookups leave all counters unchanged.
- R8: The probe returns the same physical address as a permitted main lookup, and 0 on a miss or a denied access. It never changes an age counter.
- R9: prb_ci_valid pulses, and prb_ci is reloaded, only when prb_thru is 1 and the probe either passes through or is permitted. Otherwise prb_ci keeps its previous value.
- R10: The rsp_* outputs are registered. rsp_valid is high exactly in the cycle after req_valid was high, and the same holds for prb_rsp_valid and prb_valid.
- R11: The write port stores wr_data into a record on the clock edge, and a lookup in the next cycle sees it. wr_sel=0 selects the match record, laid out as tag in [31:15], age counter in [1:1] and valid in [0]. wr_sel=1 selects the translate record, laid out as page number in [31:13], then bits [4:0] = {sup write, sup read, user write, user read, cache-inhibit}. rd_data returns the selected record in the same layout, with unused bits 0.
- R12: If a write lands in the same set as a matching main lookup in the same cycle, the write is applied and the lookup's ageing of that set is dropped. The lookup result itself is unaffected.
- R13: Reset clears every record (all ways invalid) and forces rsp_valid, rsp_paddr, rsp_ci, rsp_kind and all probe outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable; 0 means pass-through |
| req_valid | input | 1 | Main lookup strobe |
| req_vaddr | input | 32 | Main lookup virtual address |
| req_write | input | 1 | Main lookup is a write |
| req_super | input | 1 | Main lookup in supervisor mode |
| rsp_valid | output | 1 | Main result valid (one cycle after strobe) |
| rsp_paddr | output | 32 | Main physical address |
| rsp_ci | output | 1 | Main cache-inhibit flag |
| rsp_kind | output | 2 | Result: 0 hit, 1 miss, 2 page fault |
| prb_valid | input | 1 | Probe strobe |
| prb_vaddr | input | 32 | Probe virtual address |
| prb_write | input | 1 | Probe checks write permission |
| prb_super | input | 1 | Probe checks supervisor permission |
| prb_thru | input | 1 | Probe may update its cache-inhibit output |
| prb_rsp_valid | output | 1 | Probe result valid |
| prb_paddr | output | 32 | Probe physical address, 0 on failure |
| prb_ci_valid | output | 1 | Probe reloaded prb_ci this cycle |
| prb_ci | output | 1 | Probe cache-inhibit flag |
| wr_en | input | 1 | Record write strobe |
| wr_sel | input | 1 | 0 match record, 1 translate record |
| wr_set | input | 2 | Set written |
| wr_way | input | 1 | Way written |
| wr_data | input | 32 | Record contents |
| rd_sel | input | 1 | 0 match record, 1 translate record |
| rd_set | input | 2 | Set read |
| rd_way | input | 1 | Way read |
| rd_data | output | 32 | Record contents read back |

## Verification
The table of vectors applies pass-through addresses on both sides of the 0x80000000 boundary. It then sends each combination of privilege and access direction against entries whose enables differ, so that every enable bit is shown to be checked by exactly the matching combination. It also covers an invalid entry, a known tag placed in the wrong set, a tag one bit away from a stored one, and a set in which two ways hold the same tag. Directed sequences read the age counters back after a hit, after a faulting hit, after a miss and after a pass-through. This separates "age on any match" from "age only on success". A write and a lookup are made to collide in one set. Probes are interleaved with those read-backs, and with prb_thru toggled, to show that the probe leaves counters and the held cache-inhibit flag untouched.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    // Configuration of the translator
    localparam int ADDR_W  = 32;
    localparam int PAGE_SH = 13;
    localparam int SET_SH  = 2;
    localparam int NWAYS   = 2;

    // Derived geometry
    localparam int NSETS   = 1 << SET_SH;
    localparam int TAG_LSB = PAGE_SH + SET_SH;
    localparam int TAG_W   = ADDR_W - TAG_LSB;
    localparam int PPN_W   = ADDR_W - PAGE_SH;
    localparam int LRU_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1;
    localparam int WAY_W   = LRU_W;
    localparam int PERM_BITS = 5;
    localparam logic [LRU_W-1:0] LRU_TOP = LRU_W'(NWAYS - 1);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_FAULT = 2'd2
    } res_e;

    typedef struct packed {
        logic [TAG_W-1:0] vpn;
        logic [LRU_W-1:0] lru;
        logic             valid;
    } match_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             swe;
        logic             sre;
        logic             uwe;
        logic             ure;
        logic             ci;
    } trans_t;

    typedef struct packed {
        addr_t pa;
        logic  ci;
        res_e  kind;
    } xres_t;

    function automatic logic perm_ok(input logic sup, input logic wr,
                                     input logic sre, input logic swe,
                                     input logic ure, input logic uwe);
        if (sup) return wr ? swe : sre;
        return wr ? uwe : ure;
    endfunction

endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
    import dtlb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [SET_SH-1:0]       wr_set,
    input  logic [WAY_W-1:0]        wr_way,
    input  addr_t                   wr_data,
    input  logic                    age_en,
    input  logic [SET_SH-1:0]       age_set,
    input  logic [WAY_W-1:0]        age_way,
    input  logic [SET_SH-1:0]       a_set,
    output match_t [NWAYS-1:0]      a_match,
    output trans_t [NWAYS-1:0]      a_trans,
    input  logic [SET_SH-1:0]       b_set,
    output match_t [NWAYS-1:0]      b_match,
    output trans_t [NWAYS-1:0]      b_trans,
    input  logic                    rd_sel,
    input  logic [SET_SH-1:0]       rd_set,
    input  logic [WAY_W-1:0]        rd_way,
    output addr_t                   rd_data
);

    match_t mtab [NSETS][NWAYS];
    trans_t ttab [NSETS][NWAYS];

    match_t wr_m;
    trans_t wr_t;
    logic   age_go;
    logic   wr_spare_unused;

    // Unpack the software word into the two record layouts
    assign wr_m.vpn   = wr_data[ADDR_W-1:TAG_LSB];
    assign wr_m.lru   = wr_data[LRU_W:1];
    assign wr_m.valid = wr_data[0];
    assign wr_t.ppn   = wr_data[ADDR_W-1:PAGE_SH];
    assign wr_t.swe   = wr_data[4];
    assign wr_t.sre   = wr_data[3];
    assign wr_t.uwe   = wr_data[2];
    assign wr_t.ure   = wr_data[1];
    assign wr_t.ci    = wr_data[0];
    assign wr_spare_unused = ^wr_data[PAGE_SH-1:PERM_BITS];

    // A software write to the set wins over ageing of that set
    assign age_go = age_en && !(wr_en && (wr_set == age_set));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    mtab[s][w] <= '0;
                    ttab[s][w] <= '0;
                end
            end
        end else begin
            if (age_go) begin
                for (int w = 0; w < NWAYS; w++) begin
                    if (WAY_W'(w) == age_way)
                        mtab[age_set][w].lru <= LRU_TOP;
                    else if (mtab[age_set][w].lru != '0)
                        mtab[age_set][w].lru <= mtab[age_set][w].lru - 1'b1;
                end
            end
            if (wr_en && (int'(wr_way) < NWAYS)) begin
                if (wr_sel) ttab[wr_set][wr_way] <= wr_t;
                else        mtab[wr_set][wr_way] <= wr_m;
            end
        end
    end

    // Per-way views of the two sets being looked up
    for (genvar w = 0; w < NWAYS; w++) begin : g_view
        assign a_match[w] = mtab[a_set][w];
        assign a_trans[w] = ttab[a_set][w];
        assign b_match[w] = mtab[b_set][w];
        assign b_trans[w] = ttab[b_set][w];
    end

    // Software read-back in the write layout
    match_t rd_m;
    trans_t rd_t;
    assign rd_m = mtab[rd_set][rd_way];
    assign rd_t = ttab[rd_set][rd_way];

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[ADDR_W-1:PAGE_SH] = rd_t.ppn;
            rd_data[PERM_BITS-1:0]    = {rd_t.swe, rd_t.sre, rd_t.uwe, rd_t.ure, rd_t.ci};
        end else begin
            rd_data[ADDR_W-1:TAG_LSB] = rd_m.vpn;
            rd_data[LRU_W:1]          = rd_m.lru;
            rd_data[0]                = rd_m.valid;
        end
    end

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
    import dtlb_pkg::*;
(
    input  logic [TAG_W-1:0]        tag,
    input  logic [PAGE_SH-1:0]      offs,
    input  logic                    is_wr,
    input  logic                    is_sup,
    input  match_t [NWAYS-1:0]      mset,
    input  trans_t [NWAYS-1:0]      tset,
    output logic                    hit,
    output logic [WAY_W-1:0]        way,
    output logic                    allow,
    output addr_t                   pa,
    output logic                    ci
);

    trans_t sel;
    logic [NWAYS-1:0] lru_bits_unused;

    for (genvar w = 0; w < NWAYS; w++) begin : g_sink
        assign lru_bits_unused[w] = ^mset[w].lru;
    end

    // Ascending scan: a later match overrides, so the highest way wins
    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (mset[w].valid && (mset[w].vpn == tag)) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end

    assign sel   = tset[way];
    assign allow = perm_ok(is_sup, is_wr, sel.sre, sel.swe, sel.ure, sel.uwe);
    assign pa    = {sel.ppn, offs};
    assign ci    = sel.ci;

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter bit MMU_FITTED = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xlat_en,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_vaddr,
    input  logic                req_write,
    input  logic                req_super,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic                rsp_ci,
    output logic [1:0]          rsp_kind,
    input  logic                prb_valid,
    input  logic [ADDR_W-1:0]   prb_vaddr,
    input  logic                prb_write,
    input  logic                prb_super,
    input  logic                prb_thru,
    output logic                prb_rsp_valid,
    output logic [ADDR_W-1:0]   prb_paddr,
    output logic                prb_ci_valid,
    output logic                prb_ci,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [SET_SH-1:0]   wr_set,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic [ADDR_W-1:0]   wr_data,
    input  logic                rd_sel,
    input  logic [SET_SH-1:0]   rd_set,
    input  logic [WAY_W-1:0]    rd_way,
    output logic [ADDR_W-1:0]   rd_data
);

    logic xlate_on;

    if (MMU_FITTED) begin : g_fitted
        assign xlate_on = xlat_en;
    end else begin : g_absent
        logic en_unused;
        assign en_unused = xlat_en;
        assign xlate_on  = 1'b0;
    end

    // Set selection for both lookup ports
    logic [SET_SH-1:0] m_set, p_set;
    assign m_set = req_vaddr[TAG_LSB-1:PAGE_SH];
    assign p_set = prb_vaddr[TAG_LSB-1:PAGE_SH];

    match_t [NWAYS-1:0] m_match, p_match;
    trans_t [NWAYS-1:0] m_trans, p_trans;

    logic             m_hit, m_allow, m_hci;
    logic [WAY_W-1:0] m_way;
    addr_t            m_hpa;
    logic             p_hit, p_allow, p_hci;
    logic [WAY_W-1:0] p_way_unused;
    addr_t            p_hpa;
    logic             age_en;

    dtlb_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_set  (wr_set),
        .wr_way  (wr_way),
        .wr_data (wr_data),
        .age_en  (age_en),
        .age_set (m_set),
        .age_way (m_way),
        .a_set   (m_set),
        .a_match (m_match),
        .a_trans (m_trans),
        .b_set   (p_set),
        .b_match (p_match),
        .b_trans (p_trans),
        .rd_sel  (rd_sel),
        .rd_set  (rd_set),
        .rd_way  (rd_way),
        .rd_data (rd_data)
    );

    dtlb_lookup u_main (
        .tag    (req_vaddr[ADDR_W-1:TAG_LSB]),
        .offs   (req_vaddr[PAGE_SH-1:0]),
        .is_wr  (req_write),
        .is_sup (req_super),
        .mset   (m_match),
        .tset   (m_trans),
        .hit    (m_hit),
        .way    (m_way),
        .allow  (m_allow),
        .pa     (m_hpa),
        .ci     (m_hci)
    );

    dtlb_lookup u_probe (
        .tag    (prb_vaddr[ADDR_W-1:TAG_LSB]),
        .offs   (prb_vaddr[PAGE_SH-1:0]),
        .is_wr  (prb_write),
        .is_sup (prb_super),
        .mset   (p_match),
        .tset   (p_trans),
        .hit    (p_hit),
        .way    (p_way_unused),
        .allow  (p_allow),
        .pa     (p_hpa),
        .ci     (p_hci)
    );

    // Main result: pass-through, hit, miss or fault
    xres_t m_res;
    always_comb begin
        m_res.pa   = req_vaddr;
        m_res.ci   = req_vaddr[ADDR_W-1];
        m_res.kind = RES_HIT;
        age_en     = 1'b0;
        if (xlate_on) begin
            if (!m_hit) begin
                m_res.pa   = '0;
                m_res.ci   = 1'b0;
                m_res.kind = RES_MISS;
            end else begin
                age_en = req_valid;
                if (m_allow) begin
                    m_res.pa = m_hpa;
                    m_res.ci = m_hci;
                end else begin
                    m_res.pa   = '0;
                    m_res.ci   = 1'b0;
                    m_res.kind = RES_FAULT;
                end
            end
        end
    end

    // Probe result: never faults, zero on failure
    addr_t p_pa;
    logic  p_civ, p_ci;
    always_comb begin
        if (!xlate_on) begin
            p_pa  = prb_vaddr;
            p_civ = prb_thru;
            p_ci  = prb_vaddr[ADDR_W-1];
        end else if (p_hit && p_allow) begin
            p_pa  = p_hpa;
            p_civ = prb_thru;
            p_ci  = p_hci;
        end else begin
            p_pa  = '0;
            p_civ = 1'b0;
            p_ci  = 1'b0;
        end
    end

    xres_t rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_q         <= '0;
            prb_rsp_valid <= 1'b0;
            prb_paddr     <= '0;
            prb_ci_valid  <= 1'b0;
            prb_ci        <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            if (req_valid) rsp_q <= m_res;
            prb_rsp_valid <= prb_valid;
            prb_ci_valid  <= prb_valid && p_civ;
            if (prb_valid) prb_paddr <= p_pa;
            if (prb_valid && p_civ) prb_ci <= p_ci;
        end
    end

    assign rsp_paddr = rsp_q.pa;
    assign rsp_ci    = rsp_q.ci;
    assign rsp_kind  = rsp_q.kind;

endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk
    import dtlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              xlat_en,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_ci,
    input logic [1:0]        rsp_kind,
    input logic              prb_valid,
    input logic              prb_thru,
    input logic              prb_rsp_valid,
    input logic              prb_ci_valid
);

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r10_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r10_prb_follows: assert property (@(posedge clk) disable iff (rst)
        prb_valid |=> prb_rsp_valid);

    a_r1_passthrough: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xlat_en) |=>
            (rsp_paddr == $past(req_vaddr)) && (rsp_ci == $past(req_vaddr[ADDR_W-1]))
            && (rsp_kind == 2'd0));

    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd1) |-> (rsp_paddr == '0) && !rsp_ci);

    // R3 and R4: a denied access returns nothing
    a_r3_fault_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd2) |-> (rsp_paddr == '0) && !rsp_ci);

    a_r5_kind_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_kind != 2'd3));

    a_r9_ci_needs_thru: assert property (@(posedge clk) disable iff (rst)
        prb_ci_valid |-> $past(prb_valid && prb_thru));

endmodule

bind dtlb_xlate dtlb_xlate_chk u_chk (.*);

// File: tb/dtlb_xlate_test.sv
module dtlb_xlate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xlat_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_ci;
    logic [1:0]  rsp_kind;
    logic        prb_valid = 1'b0;
    logic [31:0] prb_vaddr = '0;
    logic        prb_write = 1'b0;
    logic        prb_super = 1'b0;
    logic        prb_thru = 1'b0;
    logic        prb_rsp_valid;
    logic [31:0] prb_paddr;
    logic        prb_ci_valid;
    logic        prb_ci;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [1:0]  wr_set = '0;
    logic [0:0]  wr_way = '0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [1:0]  rd_set = '0;
    logic [0:0]  rd_way = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    always #5ns clk = ~clk;

    dtlb_xlate uut (.*);

    // Tags and page numbers used by the table
    localparam logic [16:0] T0 = 17'h00123;
    localparam logic [16:0] T1 = 17'h1ABCD;
    localparam logic [16:0] T2 = 17'h00042;
    localparam logic [16:0] T3 = 17'h00777;
    localparam logic [18:0] P0 = 19'h40001;
    localparam logic [18:0] P1 = 19'h7FFFF;
    localparam logic [18:0] PA = 19'h00AAA;
    localparam logic [18:0] PB = 19'h12345;

    typedef struct packed {
        logic        xen;
        logic        sup;
        logic        wr;
        logic [31:0] va;
        logic [31:0] pa;
        logic        ci;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 1'b0, 32'h8000_1234, 32'h8000_1234, 1'b1, 2'd0},
        '{1'b0, 1'b1, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 2'd0},
        '{1'b1, 1'b1, 1'b0, {T0, 2'd1, 13'h0ABC}, {P0, 13'h0ABC}, 1'b0, 2'd0},
        '{1'b1, 1'b1, 1'b1, {T0, 2'd1, 13'h0ABC}, {P0, 13'h0ABC}, 1'b0, 2'd0},
        '{1'b1, 1'b0, 1'b0, {T0, 2'd1, 13'h0ABC}, {P0, 13'h0ABC}, 1'b0, 2'd0},
        '{1'b1, 1'b0, 1'b1, {T0, 2'd1, 13'h0ABC}, 32'h0, 1'b0, 2'd2},
        '{1'b1, 1'b1, 1'b0, {T1, 2'd1, 13'h0000}, 32'h0, 1'b0, 2'd2},
        '{1'b1, 1'b1, 1'b1, {T1, 2'd1, 13'h0000}, 32'h0, 1'b0, 2'd2},
        '{1'b1, 1'b0, 1'b1, {T1, 2'd1, 13'h1FFF}, {P1, 13'h1FFF}, 1'b1, 2'd0},
        '{1'b1, 1'b0, 1'b0, {T2, 2'd2, 13'h0010}, 32'h0, 1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b0, {T0, 2'd2, 13'h0ABC}, 32'h0, 1'b0, 2'd1},
        '{1'b1, 1'b0, 1'b0, {T3, 2'd3, 13'h0555}, {PB, 13'h0555}, 1'b0, 2'd0},
        '{1'b1, 1'b1, 1'b0, {17'h1ABCC, 2'd1, 13'h0000}, 32'h0, 1'b0, 2'd1}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1:       return "R1 passthrough";
            2, 3:       return "R3 supervisor allowed, R5 address";
            4:          return "R4 user read allowed";
            5:          return "R4 user write denied";
            6, 7:       return "R3 supervisor denied";
            8:          return "R4 user write allowed, R5 ci";
            9, 10, 12:  return "R6 miss, R2 tag/valid/set";
            default:    return "R2 highest way wins";
        endcase
    endfunction

    function automatic logic [31:0] mword(logic [16:0] tag, logic lru, logic v);
        return {tag, 13'h0, lru, v};
    endfunction

    function automatic logic [31:0] tword(logic [18:0] ppn, logic [4:0] perm);
        return {ppn, 8'h0, perm};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(logic sel, int set, int way, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_set = 2'(set); wr_way = 1'(way); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic sel, int set, int way, logic [31:0] exp);
        rd_sel = sel; rd_set = 2'(set); rd_way = 1'(way);
        #1ns;
        chk(tag, rd_data, exp);
    endtask

    task automatic do_req(logic xen, logic [31:0] va, logic wr, logic sup);
        @(negedge clk);
        xlat_en = xen; req_vaddr = va; req_write = wr; req_super = sup; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_prb(logic xen, logic [31:0] va, logic wr, logic sup, logic thru);
        @(negedge clk);
        xlat_en = xen; prb_vaddr = va; prb_write = wr; prb_super = sup; prb_thru = thru;
        prb_valid = 1'b1;
        @(negedge clk);
        prb_valid = 1'b0;
    endtask

    initial begin
        #2ms;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13: reset state
        chk("R13 rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R13 rsp_paddr", rsp_paddr, 32'h0);
        chk("R13 rsp_kind", 32'(rsp_kind), 32'h0);
        chk("R13 prb outputs", {28'h0, prb_rsp_valid, prb_ci_valid, prb_ci, 1'b0}, 32'h0);
        chk("R13 prb_paddr", prb_paddr, 32'h0);
        rd_chk("R13 match cleared", 1'b0, 0, 0, 32'h0);
        rd_chk("R13 translate cleared", 1'b1, 3, 1, 32'h0);

        // R11: load entries and read them back
        put(1'b0, 1, 0, mword(T0, 1'b0, 1'b1));
        put(1'b1, 1, 0, tword(P0, 5'h1A));
        put(1'b0, 1, 1, mword(T1, 1'b0, 1'b1));
        put(1'b1, 1, 1, tword(P1, 5'h07));
        put(1'b0, 2, 0, mword(T2, 1'b0, 1'b0));
        put(1'b1, 2, 0, tword(PA, 5'h1E));
        put(1'b0, 3, 0, mword(T3, 1'b0, 1'b1));
        put(1'b1, 3, 0, tword(PA, 5'h1E));
        put(1'b0, 3, 1, mword(T3, 1'b0, 1'b1));
        put(1'b1, 3, 1, tword(PB, 5'h1E));
        rd_chk("R11 match readback", 1'b0, 1, 1, mword(T1, 1'b0, 1'b1));
        rd_chk("R11 translate readback", 1'b1, 1, 0, tword(P0, 5'h1A));

        // Table: R1 R2 R3 R4 R5 R6 under distinct patterns
        for (int i = 0; i < NV; i++) begin
            do_req(VT[i].xen, VT[i].va, VT[i].wr, VT[i].sup);
            chk({vtag(i), " valid"}, 32'(rsp_valid), 32'h1);
            chk({vtag(i), " kind"}, 32'(rsp_kind), 32'(VT[i].kind));
            chk({vtag(i), " paddr"}, rsp_paddr, VT[i].pa);
            chk({vtag(i), " ci"}, 32'(rsp_ci), 32'(VT[i].ci));
        end

        // R6: a miss installs nothing
        rd_chk("R6 no refill way0", 1'b0, 2, 0, mword(T2, 1'b0, 1'b0));
        rd_chk("R6 no refill way1", 1'b0, 2, 1, 32'h0);

        // R10: response drops when no request
        @(negedge clk);
        chk("R10 rsp_valid idle", 32'(rsp_valid), 32'h0);

        // R7: ageing on hit, faulting hit, not on miss or passthrough
        put(1'b0, 1, 0, mword(T0, 1'b0, 1'b1));
        put(1'b0, 1, 1, mword(T1, 1'b1, 1'b1));
        do_req(1'b1, {T0, 2'd1, 13'h0}, 1'b0, 1'b1);
        rd_chk("R7 hit way set to max", 1'b0, 1, 0, mword(T0, 1'b1, 1'b1));
        rd_chk("R7 other way decremented", 1'b0, 1, 1, mword(T1, 1'b0, 1'b1));
        do_req(1'b1, {T1, 2'd1, 13'h0}, 1'b0, 1'b1);
        chk("R7 faulting lookup kind", 32'(rsp_kind), 32'h2);
        rd_chk("R7 faulting hit ages", 1'b0, 1, 1, mword(T1, 1'b1, 1'b1));
        rd_chk("R7 faulting hit decrements", 1'b0, 1, 0, mword(T0, 1'b0, 1'b1));
        do_req(1'b1, {T2, 2'd1, 13'h0}, 1'b0, 1'b1);
        do_req(1'b0, {T0, 2'd1, 13'h0}, 1'b0, 1'b1);
        rd_chk("R7 miss/bypass keep way1", 1'b0, 1, 1, mword(T1, 1'b1, 1'b1));
        rd_chk("R7 miss/bypass keep way0", 1'b0, 1, 0, mword(T0, 1'b0, 1'b1));

        // R12: write and ageing collide in set 1
        put(1'b0, 1, 0, mword(T0, 1'b1, 1'b1));
        put(1'b0, 1, 1, mword(T1, 1'b0, 1'b1));
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_set = 2'd1; wr_way = 1'b0;
        wr_data = mword(T0, 1'b0, 1'b1);
        xlat_en = 1'b1; req_vaddr = {T1, 2'd1, 13'h0042}; req_write = 1'b1;
        req_super = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R12 lookup kind", 32'(rsp_kind), 32'h0);
        chk("R12 lookup paddr", rsp_paddr, {P1, 13'h0042});
        rd_chk("R12 write applied", 1'b0, 1, 0, mword(T0, 1'b0, 1'b1));
        rd_chk("R12 ageing dropped", 1'b0, 1, 1, mword(T1, 1'b0, 1'b1));

        // R8 and R9: probe behaviour
        do_prb(1'b0, 32'h9000_0010, 1'b0, 1'b0, 1'b1);
        chk("R9 bypass probe paddr", prb_paddr, 32'h9000_0010);
        chk("R9 bypass probe ci_valid", 32'(prb_ci_valid), 32'h1);
        chk("R9 bypass probe ci", 32'(prb_ci), 32'h1);
        do_prb(1'b1, {T0, 2'd1, 13'h0123}, 1'b0, 1'b1, 1'b0);
        chk("R8 probe valid", 32'(prb_rsp_valid), 32'h1);
        chk("R8 probe hit paddr", prb_paddr, {P0, 13'h0123});
        chk("R9 no thru ci_valid", 32'(prb_ci_valid), 32'h0);
        chk("R9 no thru ci held", 32'(prb_ci), 32'h1);
        rd_chk("R8 probe leaves age", 1'b0, 1, 0, mword(T0, 1'b0, 1'b1));
        do_prb(1'b1, {T0, 2'd1, 13'h0123}, 1'b0, 1'b1, 1'b1);
        chk("R9 thru ci_valid", 32'(prb_ci_valid), 32'h1);
        chk("R9 thru ci", 32'(prb_ci), 32'h0);
        do_prb(1'b1, {T1, 2'd1, 13'h0}, 1'b0, 1'b1, 1'b1);
        chk("R8 probe denied paddr", prb_paddr, 32'h0);
        chk("R9 denied ci_valid", 32'(prb_ci_valid), 32'h0);
        do_prb(1'b1, {T1, 2'd1, 13'h0}, 1'b0, 1'b0, 1'b1);
        chk("R9 ci from entry", 32'(prb_ci), 32'h1);
        do_prb(1'b1, {T2, 2'd2, 13'h0}, 1'b0, 1'b1, 1'b1);
        chk("R8 probe miss paddr", prb_paddr, 32'h0);
        rd_chk("R8 probe leaves age way1", 1'b0, 1, 1, mword(T1, 1'b0, 1'b1));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule